// File: doc/BRIEF.md
# Coefficient Shadow Memory Controller

This block holds the working copy of a compensation engine's coefficient set: one control word carrying the polarity and bypass flags, a base value, and a row of per-step increments. All of them are stored as equal-width words in one flat address space. After reset, a sequencer fills the working words from a non-volatile store, one word per handshake, without any host action. The compensation engine may compute only after two events: the fill has finished and the temperature sensor has reported its first conversion. The two events may arrive in either order.

A host port reads the working words at any time. The host may change a word only at the write-enabled access level and only while the controller is idle. A change takes effect in the working copy at once. It reaches the non-volatile store only through an explicit commit (burn) command, which writes every working word back in ascending address order. A saturating counter records the number of completed commits. Reset discards all uncommitted changes, because the next fill reloads the stored values.

Top module: `coef_shadow_ctrl`

## Requirements
- R1: After reset is released, `busy` is 1 and `nv_we` is 0. The controller reads word addresses 0 to NUM_WORDS-1 in ascending order, one per `nv_ack`, and loads each into the working copy. `busy` falls after the last word.
- R2: `compute_en` becomes 1 only when the fill has completed and a `conv_done` pulse has been seen since reset, in either order. It then stays 1 until reset. While `compute_en` is 0, `eng_data` reads 0. Once it is 1, `eng_data` equals the working word at `eng_addr`.
- R3: When `host_wr` is 1, `access_lvl` equals 2'b10 and `busy` is 0, the addressed working word takes `host_wdata` at the clock edge. The new value appears on `host_rdata` and `eng_data` in the next cycle.
- R4: A host write made at any `access_lvl` other than 2'b10 leaves every working word unchanged.
- R5: While `busy` is 1, host writes and burn requests are ignored. A burn request made during a burn does not start a second burn.
- R6: A burn request (`host_burn` at level 2'b10 while idle) raises `busy` at the next edge. The controller then writes every working word to the store, ascending, and leaves the working words unchanged. Host writes alone never reach the store, so after a reset the last committed values return.
- R7: `nv_we` is 1 during a burn and 0 during a fill. `nv_req`, `nv_addr` and `nv_we` are held until `nv_ack`.
- R8: `burn_count` is 0 after reset. It increases by one at the acknowledgement of the last word of each burn and saturates at 2^CNT_W-1.
- R9: A burn request at any `access_lvl` other than 2'b10 is ignored: `busy` stays 0 and `burn_count` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts a fill |
| access_lvl | input | 2 | Current access level; 2'b10 enables writes and burns |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word address for read and write |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Working word at host_addr |
| host_burn | input | 1 | Commit request |
| busy | output | 1 | Fill or burn in progress |
| burn_count | output | CNT_W | Saturating count of completed burns |
| conv_done | input | 1 | Temperature conversion complete pulse |
| compute_en | output | 1 | Compensation engine may compute |
| eng_addr | input | ADDR_W | Engine read address |
| eng_data | output | DATA_W | Engine read data, 0 until enabled |
| nv_req | output | 1 | Store access request |
| nv_we | output | 1 | Store access is a write |
| nv_addr | output | ADDR_W | Store word address |
| nv_wdata | output | DATA_W | Store write data |
| nv_rdata | input | DATA_W | Store read data, valid with nv_ack |
| nv_ack | input | 1 | Store handshake acknowledge |

## Verification
The assertions check on every cycle that the store request stays steady until it is acknowledged and that addresses stay in range. They also check that compute enable never rises while a fill is in progress, that it never drops once raised, that a write at the wrong level never alters the working set, and that the commit counter never moves backwards. Other behaviour shows only in the bench's scenarios, where the bench compares against its own model of the store. These are the ascending content of a fill and a burn, the loss of uncommitted edits across reset, both arrival orders of the first conversion, the rejection of writes and repeat burns during a burn, and saturation of the counter.

// File: rtl/coef_shadow_pkg.sv
package coef_shadow_pkg;
   typedef enum logic [1:0] {
      SEQ_FILL = 2'd0,
      SEQ_IDLE = 2'd1,
      SEQ_BURN = 2'd2
   } seq_state_t;
endpackage

// File: rtl/coef_seq.sv
module coef_seq
   import coef_shadow_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burn_go,
   input  logic              nv_ack,
   output logic              nv_req,
   output logic              nv_we,
   output logic [ADDR_W-1:0] nv_addr,
   output logic              load_we,
   output logic              filled,
   output logic              burn_done
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

   seq_state_t        state;
   logic [ADDR_W-1:0] addr;
   logic              at_last;

   assign at_last   = (addr == LAST);
   assign nv_req    = (state != SEQ_IDLE);
   assign nv_we     = (state == SEQ_BURN);
   assign nv_addr   = addr;
   assign load_we   = (state == SEQ_FILL) && nv_ack;
   assign burn_done = (state == SEQ_BURN) && nv_ack && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_FILL;
         addr   <= '0;
         filled <= 1'b0;
      end else begin
         unique case (state)
            SEQ_FILL: if (nv_ack) begin
               if (at_last) begin
                  state  <= SEQ_IDLE;
                  addr   <= '0;
                  filled <= 1'b1;
               end else begin
                  addr <= addr + 1'b1;
               end
            end
            SEQ_BURN: if (nv_ack) begin
               if (at_last) begin
                  state <= SEQ_IDLE;
                  addr  <= '0;
               end else begin
                  addr <= addr + 1'b1;
               end
            end
            default: if (burn_go) begin
               state <= SEQ_BURN;
               addr  <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
   parameter int NUM_WORDS = 16,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load_we,
   input  logic [ADDR_W-1:0]                 load_addr,
   input  logic [DATA_W-1:0]                 load_data,
   input  logic                              host_we,
   input  logic [ADDR_W-1:0]                 host_addr,
   input  logic [DATA_W-1:0]                 host_wdata,
   output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);
   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (load_we && load_addr == ADDR_W'(i))
            q <= load_data;
         else if (host_we && host_addr == ADDR_W'(i))
            q <= host_wdata;
      end
      assign words[i] = q;
   end
endmodule

// File: rtl/coef_sat_counter.sv
module coef_sat_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (inc && count != TOP)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/coef_shadow_ctrl.sv
module coef_shadow_ctrl #(
   parameter int         NUM_WORDS = 16,
   parameter int         DATA_W    = 8,
   parameter int         CNT_W     = 8,
   parameter logic [1:0] WR_LEVEL  = 2'b10,
   localparam int        ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        access_lvl,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              host_burn,
   output logic              busy,
   output logic [CNT_W-1:0]  burn_count,
   input  logic              conv_done,
   output logic              compute_en,
   input  logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_data,
   output logic              nv_req,
   output logic              nv_we,
   output logic [ADDR_W-1:0] nv_addr,
   output logic [DATA_W-1:0] nv_wdata,
   input  logic [DATA_W-1:0] nv_rdata,
   input  logic              nv_ack
);
   localparam logic [ADDR_W:0] WORDS_EXT = (ADDR_W+1)'(NUM_WORDS);

   if (NUM_WORDS < 2) begin : g_chk_words
      $error("coef_shadow_ctrl: NUM_WORDS must be at least 2");
   end
   if (DATA_W < 1 || CNT_W < 1) begin : g_chk_widths
      $error("coef_shadow_ctrl: DATA_W and CNT_W must be positive");
   end

   logic                             level_ok, host_we, burn_go;
   logic                             load_we, filled, burn_done, conv_seen;
   logic [NUM_WORDS-1:0][DATA_W-1:0] work_flat;

   assign level_ok = (access_lvl == WR_LEVEL);
   assign busy     = nv_req;
   assign host_we  = host_wr && level_ok && !busy;
   assign burn_go  = host_burn && level_ok && !busy;

   coef_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .burn_go(burn_go), .nv_ack(nv_ack),
      .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr),
      .load_we(load_we), .filled(filled), .burn_done(burn_done)
   );

   coef_bank #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .load_we(load_we), .load_addr(nv_addr), .load_data(nv_rdata),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .words(work_flat)
   );

   coef_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(burn_done), .count(burn_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         conv_seen <= 1'b0;
      else if (conv_done)
         conv_seen <= 1'b1;
   end

   assign compute_en = filled && conv_seen;
   assign nv_wdata   = work_flat[nv_addr];

   always_comb begin
      host_rdata = '0;
      if ({1'b0, host_addr} < WORDS_EXT) host_rdata = work_flat[host_addr];
      eng_data = '0;
      if (compute_en && {1'b0, eng_addr} < WORDS_EXT) eng_data = work_flat[eng_addr];
   end
endmodule

// File: rtl/coef_shadow_chk.sv
module coef_shadow_chk #(
   parameter int         NUM_WORDS = 16,
   parameter int         DATA_W    = 8,
   parameter int         CNT_W     = 8,
   parameter logic [1:0] WR_LEVEL  = 2'b10,
   parameter int         ADDR_W    = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [1:0]                      access_lvl,
   input logic                            host_wr,
   input logic                            busy,
   input logic                            compute_en,
   input logic [CNT_W-1:0]                burn_count,
   input logic                            nv_req,
   input logic                            nv_we,
   input logic                            nv_ack,
   input logic [ADDR_W-1:0]               nv_addr,
   input logic [NUM_WORDS*DATA_W-1:0]     work_flat
);
   localparam logic [ADDR_W:0] WORDS_EXT = (ADDR_W+1)'(NUM_WORDS);

   AST_NV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_req && !nv_ack) |=> (nv_req && $stable(nv_addr) && $stable(nv_we))); // R7
   AST_NV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      nv_req |-> ({1'b0, nv_addr} < WORDS_EXT)); // R1
   AST_EN_NOT_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      compute_en |-> !(busy && !nv_we)); // R2
   AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      compute_en |=> compute_en); // R2
   AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && access_lvl != WR_LEVEL && !busy) |=> $stable(work_flat)); // R4
   AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      burn_count >= $past(burn_count)); // R8
endmodule

bind coef_shadow_ctrl coef_shadow_chk #(
   .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .CNT_W(CNT_W),
   .WR_LEVEL(WR_LEVEL), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .access_lvl(access_lvl), .host_wr(host_wr),
   .busy(busy), .compute_en(compute_en), .burn_count(burn_count),
   .nv_req(nv_req), .nv_we(nv_we), .nv_ack(nv_ack), .nv_addr(nv_addr),
   .work_flat(work_flat)
);

// File: tb/coef_shadow_ctrl_bench.sv
module coef_shadow_ctrl_bench;
   localparam int CLK_PERIOD  = 10;
   localparam int NW          = 16;
   localparam int DW          = 8;
   localparam int CW          = 2;
   localparam int AW          = 4;
   localparam int CONV_CYCLES = 200;
   localparam int SEED        = 32'h5eed_1234;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    access_lvl = 2'b00;
   logic          host_wr = 1'b0, host_burn = 1'b0, conv_done = 1'b0;
   logic [AW-1:0] host_addr = '0, eng_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata, eng_data, nv_wdata;
   logic          busy, compute_en, nv_req, nv_we;
   logic [CW-1:0] burn_count;
   logic [AW-1:0] nv_addr;
   logic [DW-1:0] nv_rdata = '0;
   logic          nv_ack = 1'b0;

   logic [DW-1:0] nvm     [NW];
   logic [DW-1:0] exp_nv  [NW];
   logic [DW-1:0] exp_work[NW];
   int total = 0, bad = 0;
   int exp_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   coef_shadow_ctrl #(.NUM_WORDS(NW), .DATA_W(DW), .CNT_W(CW)) u_coef_shadow_ctrl (
      .clk(clk), .rst_n(rst_n), .access_lvl(access_lvl), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_burn(host_burn), .busy(busy), .burn_count(burn_count),
      .conv_done(conv_done), .compute_en(compute_en), .eng_addr(eng_addr),
      .eng_data(eng_data), .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr),
      .nv_wdata(nv_wdata), .nv_rdata(nv_rdata), .nv_ack(nv_ack)
   );

   // store model: acknowledges after a random delay, data ready with the ack
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_ack <= 1'b0;
      end else begin
         if (nv_ack && nv_req && nv_we) nvm[nv_addr] <= nv_wdata;
         nv_ack   <= nv_req && !nv_ack && ($urandom % 2 == 0);
         nv_rdata <= nvm[nv_addr];
      end
   end

   function automatic int sat_inc(int c);
      return (c < (1 << CW) - 1) ? c + 1 : c;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc(3);
      rst_n = 1'b1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && busy; i++) cyc();
   endtask

   task automatic read_at(int a, output logic [DW-1:0] h, output logic [DW-1:0] e);
      host_addr = AW'(a);
      eng_addr  = AW'(a);
      #1;
      h = host_rdata;
      e = eng_data;
   endtask

   task automatic host_write(int a, logic [DW-1:0] d, logic [1:0] lvl);
      access_lvl = lvl;
      host_addr  = AW'(a);
      host_wdata = d;
      host_wr    = 1'b1;
      cyc();
      host_wr    = 1'b0;
   endtask

   task automatic burn(logic [1:0] lvl);
      access_lvl = lvl;
      host_burn  = 1'b1;
      cyc();
      host_burn  = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] h, e, d;
      int start, a;
      logic [1:0] lvl;
      void'($urandom(SEED));
      for (int i = 0; i < NW; i++) begin
         nvm[i]    = DW'($urandom);
         exp_nv[i] = nvm[i];
      end

      // reset and fill
      do_reset();
      chk("R1 busy after reset", busy, 1);
      chk("R7 no write during fill", nv_we, 0);
      chk("R2 enable low after reset", compute_en, 0);
      chk("R8 counter reset", burn_count, 0);
      start = 0;
      while (busy && start < 5000) begin cyc(); start++; end
      for (int i = 0; i < NW; i++) begin
         read_at(i, h, e);
         exp_work[i] = exp_nv[i];
         chk("R1 filled word", h, exp_nv[i]);
      end
      chk("R2 enable waits for conversion", compute_en, 0);
      chk("R2 engine data zero", eng_data, 0);

      // first conversion after the fill
      if (start < CONV_CYCLES) cyc(CONV_CYCLES - start);
      conv_done = 1'b1; cyc(); conv_done = 1'b0;
      chk("R2 enable after fill and conversion", compute_en, 1);
      read_at(7, h, e);
      chk("R2 engine data after enable", e, exp_work[7]);

      // random writes at random levels
      for (int n = 0; n < 60; n++) begin
         a   = $urandom % NW;
         d   = DW'($urandom);
         lvl = 2'($urandom);
         if (n < 4) lvl = 2'b10;
         host_write(a, d, lvl);
         if (lvl == 2'b10) exp_work[a] = d;
         read_at(a, h, e);
         if (lvl == 2'b10) begin
            chk("R3 accepted write host view", h, exp_work[a]);
            chk("R3 accepted write engine view", e, exp_work[a]);
         end else begin
            chk("R4 write at wrong level ignored", h, exp_work[a]);
         end
      end

      // burn with a write and a second burn attempted while busy
      burn(2'b10);
      chk("R6 busy during burn", busy, 1);
      chk("R7 write strobe during burn", nv_we, 1);
      host_write(3, exp_work[3] ^ 8'hFF, 2'b10);
      burn(2'b10);
      wait_idle();
      exp_cnt = sat_inc(exp_cnt);
      for (int i = 0; i < NW; i++) exp_nv[i] = exp_work[i];
      chk("R5 single burn counted", burn_count, exp_cnt);
      read_at(3, h, e);
      chk("R5 write while busy ignored", h, exp_work[3]);
      for (int i = 0; i < NW; i++) begin
         chk("R6 store holds committed word", nvm[i], exp_nv[i]);
         read_at(i, h, e);
         chk("R6 working word kept by burn", h, exp_work[i]);
      end

      // burn at the wrong level
      burn(2'b01);
      chk("R9 burn at wrong level no busy", busy, 0);
      cyc(2);
      chk("R9 burn at wrong level no count", burn_count, exp_cnt);

      // counter saturation
      for (int k = 0; k < 3; k++) begin
         burn(2'b10);
         wait_idle();
         exp_cnt = sat_inc(exp_cnt);
         chk("R8 burn count", burn_count, exp_cnt);
      end
      chk("R8 saturated value", burn_count, (1 << CW) - 1);

      // uncommitted edit is lost across reset; conversion before fill ends
      d = exp_work[5] ^ 8'h5A;
      host_write(5, d, 2'b10);
      read_at(5, h, e);
      chk("R3 edit visible before reset", h, d);
      do_reset();
      conv_done = 1'b1; cyc(); conv_done = 1'b0;
      chk("R2 enable held during fill", compute_en, busy ? 0 : 1);
      wait_idle();
      cyc();
      chk("R2 enable after early conversion", compute_en, 1);
      read_at(5, h, e);
      chk("R6 reload restores committed word", h, exp_nv[5]);
      chk("R8 counter cleared by reset", burn_count, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule